// File: doc/BRIEF.md
# Write-Qualified I/O Decoder with Sticky Flags

This block sits between a one-bit control core and its board-level inputs and outputs. It takes the 8-bit program word that the core is executing and splits it in two. The upper nibble goes back to the core as the opcode. The lower nibble selects one bit of I/O.

The core's WRITE strobe acts as an extra address bit. With WRITE low, the nibble picks one of 16 input bits and presents it on a single read line. With WRITE high, it picks one of 16 output latches. That latch takes the core's data bit on the next rising clock edge and keeps it until it is written again. Address bit 3 chooses the bank in both directions: 0 is the onboard bank and 1 is the expansion bank. Input address 0 is the onboard switch that the program reads at startup to enable I/O.

The core also raises two flag lines, each for a single cycle. Each one sets an indicator latch that stays on. Only a synchronous reset turns it off. The same reset also clears every output latch.

Top module: `wq_io_decoder`

## Requirements
- R1: `opcode` always equals bits 7..4 of `progWord`, with no clock delay.
- R2: While `writeStb` is low, `readBit` shows, in the same cycle, the input chosen by address = `progWord[3:0]`: `boardIn[addr[2:0]]` when addr[3]=0 and `expIn[addr[2:0]]` when addr[3]=1.
- R3: Input address 0 (progWord low nibble 4'h0, WRITE low) reads `boardIn[0]`, the I/O enable switch.
- R4: While `writeStb` is high, `readBit` is 0 whatever the inputs are.
- R5: At a rising edge with `writeStb` high and `rst` low, the output latch at address addr takes `dataOut`. Output index addr maps to `boardOut[addr[2:0]]` when addr[3]=0 and to `expOut[addr[2:0]]` when addr[3]=1. The new value is visible after that edge.
- R6: A write changes only the addressed latch. While `writeStb` is low, no output latch changes, even while the address and `dataOut` change.
- R7: A one-cycle high on `flagZeroPulse` or `flagFPulse` sets `flagZeroLed` or `flagFLed` at the next edge. The LED then stays set through any later activity until reset.
- R8: An edge with `rst` high clears all 16 output latches and both flag LEDs. Reset takes priority over a write or a flag pulse in the same cycle.
- R9: The two flag latches are independent: a pulse on one never sets the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all latches update on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| progWord | input | 8 | Current program word: opcode nibble and I/O address nibble |
| writeStb | input | 1 | Core WRITE strobe; selects the output space and enables the latch write |
| dataOut | input | 1 | Data bit from the core for the addressed output latch |
| flagZeroPulse | input | 1 | Single-cycle pulse of the first flag |
| flagFPulse | input | 1 | Single-cycle pulse of the second flag |
| boardIn | input | 8 | Onboard input bits; bit 0 is the I/O enable switch |
| expIn | input | 8 | Expansion input bits |
| opcode | output | 4 | Opcode nibble returned to the core |
| readBit | output | 1 | Selected input bit, 0 during writes |
| boardOut | output | 8 | Onboard output latches |
| expOut | output | 8 | Expansion output latches |
| flagZeroLed | output | 1 | Sticky indicator for the first flag |
| flagFLed | output | 1 | Sticky indicator for the second flag |

## Verification
The assertions assume three things. `progWord`, `writeStb`, `dataOut` and the flag pulses are stable around each rising edge. The core never changes the address while WRITE is high. `rst` is high from the first edge, so all latches start from a known value. The stimulus changes every input a short time after a rising edge and holds it for the whole cycle. Each write is a single cycle with the address already settled. Reset is held for several edges before anything else happens.

// File: rtl/io_dec_pkg.sv
package io_dec_pkg;

  // Strobes passed from the decode control to the latch/mux datapath.
  typedef struct packed {
    logic clrAll;       // synchronous clear of every latch
    logic wrEn;         // output-space access: capture at the edge
    logic rdEn;         // input-space access: drive the read line
    logic expSel;       // bank select: 0 onboard, 1 expansion
    logic setFlagZero;  // raise first sticky indicator
    logic setFlagF;     // raise second sticky indicator
  } ioStrobes_t;

  localparam int unsigned NUM_BANKS = 2;

endpackage

// File: rtl/io_dec_ctrl.sv
module io_dec_ctrl
  import io_dec_pkg::*;
#(
  parameter int unsigned WORD_W = 8,
  parameter int unsigned OP_W   = 4
) (
  input  logic                          rst,
  input  logic [WORD_W-1:0]             progWord,
  input  logic                          writeStb,
  input  logic                          flagZeroPulse,
  input  logic                          flagFPulse,
  output logic [OP_W-1:0]               opcode,
  output logic [WORD_W-OP_W-2:0]        bitSel,
  output ioStrobes_t                    strobes
);

  localparam int unsigned ADDR_W = WORD_W - OP_W;
  localparam int unsigned SEL_W  = ADDR_W - 1;

  logic [ADDR_W-1:0] ioAddr;

  // Split the program word: opcode on top, I/O address below.
  assign opcode = progWord[WORD_W-1 -: OP_W];
  assign ioAddr = progWord[ADDR_W-1:0];

  // The top address bit picks the bank; the rest picks the bit.
  assign bitSel = ioAddr[SEL_W-1:0];

  always_comb begin
    strobes             = '0;
    strobes.clrAll      = rst;
    // WRITE acts as the extra address bit that chooses the space.
    strobes.wrEn        = writeStb;
    strobes.rdEn        = !writeStb;
    strobes.expSel      = ioAddr[ADDR_W-1];
    strobes.setFlagZero = flagZeroPulse;
    strobes.setFlagF    = flagFPulse;
  end

endmodule

// File: rtl/io_dec_dp.sv
module io_dec_dp
  import io_dec_pkg::*;
#(
  parameter int unsigned ADDR_W = 4
) (
  input  logic                            clk,
  input  ioStrobes_t                      strobes,
  input  logic [ADDR_W-2:0]               bitSel,
  input  logic                            dataOut,
  input  logic [(1 << (ADDR_W-1))-1:0]    boardIn,
  input  logic [(1 << (ADDR_W-1))-1:0]    expIn,
  output logic                            readBit,
  output logic [(1 << (ADDR_W-1))-1:0]    boardOut,
  output logic [(1 << (ADDR_W-1))-1:0]    expOut,
  output logic                            flagZeroLed,
  output logic                            flagFLed
);

  localparam int unsigned SEL_W  = ADDR_W - 1;
  localparam int unsigned BANK_W = 1 << SEL_W;

  logic [NUM_BANKS-1:0][BANK_W-1:0] bankIn;
  logic [NUM_BANKS-1:0][BANK_W-1:0] latchQ;

  assign bankIn[0] = boardIn;
  assign bankIn[1] = expIn;

  // Input side: one bit out of the selected bank, silent during writes.
  always_comb begin
    readBit = 1'b0;
    if (strobes.rdEn) begin
      readBit = bankIn[strobes.expSel][bitSel];
    end
  end

  // Output side: one addressable latch per bit, captured only at an
  // edge where the write strobe is high.
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic bankWr;
    assign bankWr = strobes.wrEn && (strobes.expSel == 1'(b));

    for (genvar i = 0; i < BANK_W; i++) begin : g_bit
      logic bitQ;
      always_ff @(posedge clk) begin
        if (strobes.clrAll) begin
          bitQ <= 1'b0;
        end else if (bankWr && (bitSel == SEL_W'(i))) begin
          bitQ <= dataOut;
        end
      end
      assign latchQ[b][i] = bitQ;
    end
  end

  assign boardOut = latchQ[0];
  assign expOut   = latchQ[1];

  // Sticky indicators: set by a pulse, cleared only by reset.
  always_ff @(posedge clk) begin
    if (strobes.clrAll) begin
      flagZeroLed <= 1'b0;
      flagFLed    <= 1'b0;
    end else begin
      if (strobes.setFlagZero) flagZeroLed <= 1'b1;
      if (strobes.setFlagF)    flagFLed    <= 1'b1;
    end
  end

endmodule

// File: rtl/wq_io_decoder.sv
module wq_io_decoder
  import io_dec_pkg::*;
#(
  parameter int unsigned WORD_W = 8,
  parameter int unsigned OP_W   = 4
) (
  input  logic                                      clk,
  input  logic                                      rst,
  input  logic [WORD_W-1:0]                         progWord,
  input  logic                                      writeStb,
  input  logic                                      dataOut,
  input  logic                                      flagZeroPulse,
  input  logic                                      flagFPulse,
  input  logic [(1 << (WORD_W-OP_W-1))-1:0]         boardIn,
  input  logic [(1 << (WORD_W-OP_W-1))-1:0]         expIn,
  output logic [OP_W-1:0]                           opcode,
  output logic                                      readBit,
  output logic [(1 << (WORD_W-OP_W-1))-1:0]         boardOut,
  output logic [(1 << (WORD_W-OP_W-1))-1:0]         expOut,
  output logic                                      flagZeroLed,
  output logic                                      flagFLed
);

  localparam int unsigned ADDR_W = WORD_W - OP_W;
  localparam int unsigned SEL_W  = ADDR_W - 1;

  ioStrobes_t        strobes;
  logic [SEL_W-1:0]  bitSel;

  io_dec_ctrl #(
    .WORD_W (WORD_W),
    .OP_W   (OP_W)
  ) u_ctrl (
    .rst           (rst),
    .progWord      (progWord),
    .writeStb      (writeStb),
    .flagZeroPulse (flagZeroPulse),
    .flagFPulse    (flagFPulse),
    .opcode        (opcode),
    .bitSel        (bitSel),
    .strobes       (strobes)
  );

  io_dec_dp #(
    .ADDR_W (ADDR_W)
  ) u_dp (
    .clk         (clk),
    .strobes     (strobes),
    .bitSel      (bitSel),
    .dataOut     (dataOut),
    .boardIn     (boardIn),
    .expIn       (expIn),
    .readBit     (readBit),
    .boardOut    (boardOut),
    .expOut      (expOut),
    .flagZeroLed (flagZeroLed),
    .flagFLed    (flagFLed)
  );

endmodule

// File: rtl/wq_io_decoder_chk.sv
module wq_io_decoder_chk #(
  parameter int unsigned WORD_W = 8,
  parameter int unsigned OP_W   = 4
) (
  input logic                                 clk,
  input logic                                 rst,
  input logic [WORD_W-1:0]                    progWord,
  input logic                                 writeStb,
  input logic                                 dataOut,
  input logic                                 flagZeroPulse,
  input logic                                 flagFPulse,
  input logic [(1 << (WORD_W-OP_W-1))-1:0]    boardIn,
  input logic [(1 << (WORD_W-OP_W-1))-1:0]    expIn,
  input logic                                 readBit,
  input logic [(1 << (WORD_W-OP_W-1))-1:0]    boardOut,
  input logic [(1 << (WORD_W-OP_W-1))-1:0]    expOut,
  input logic                                 flagZeroLed,
  input logic                                 flagFLed
);

  localparam int unsigned ADDR_W = WORD_W - OP_W;
  localparam int unsigned BANK_W = 1 << (ADDR_W - 1);

  logic [ADDR_W-1:0]   addr;
  logic [2*BANK_W-1:0] allOut;
  logic [2*BANK_W-1:0] allIn;

  assign addr   = progWord[ADDR_W-1:0];
  assign allOut = {expOut, boardOut};
  assign allIn  = {expIn, boardIn};

  // R2
  read_select_chk: assert property (@(posedge clk) disable iff (rst)
    !writeStb |-> (readBit == allIn[addr]));

  // R4
  read_quiet_on_write_chk: assert property (@(posedge clk) disable iff (rst)
    writeStb |-> !readBit);

  // R5
  write_capture_chk: assert property (@(posedge clk) disable iff (rst)
    writeStb |=> (allOut[$past(addr)] == $past(dataOut)));

  // R6
  hold_without_write_chk: assert property (@(posedge clk) disable iff (rst)
    !writeStb |=> $stable(allOut));

  // R7
  flag_zero_set_chk: assert property (@(posedge clk) disable iff (rst)
    flagZeroPulse |=> flagZeroLed);

  // R7
  flag_f_set_chk: assert property (@(posedge clk) disable iff (rst)
    flagFPulse |=> flagFLed);

  // R7
  flag_zero_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    flagZeroLed |=> flagZeroLed);

  // R7
  flag_f_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    flagFLed |=> flagFLed);

  // R9
  flag_zero_indep_chk: assert property (@(posedge clk) disable iff (rst)
    (!flagZeroLed && !flagZeroPulse) |=> !flagZeroLed);

  // R9
  flag_f_indep_chk: assert property (@(posedge clk) disable iff (rst)
    (!flagFLed && !flagFPulse) |=> !flagFLed);

  // R8
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (allOut == '0 && !flagZeroLed && !flagFLed));

endmodule

bind wq_io_decoder wq_io_decoder_chk #(
  .WORD_W (WORD_W),
  .OP_W   (OP_W)
) u_chk (
  .clk           (clk),
  .rst           (rst),
  .progWord      (progWord),
  .writeStb      (writeStb),
  .dataOut       (dataOut),
  .flagZeroPulse (flagZeroPulse),
  .flagFPulse    (flagFPulse),
  .boardIn       (boardIn),
  .expIn         (expIn),
  .readBit       (readBit),
  .boardOut      (boardOut),
  .expOut        (expOut),
  .flagZeroLed   (flagZeroLed),
  .flagFLed      (flagFLed)
);

// File: tb/sim_wq_io_decoder.sv
`timescale 1ns/1ps
module sim_wq_io_decoder;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] progWord = '0;
  logic       writeStb = 1'b0;
  logic       dataOut = 1'b0;
  logic       flagZeroPulse = 1'b0;
  logic       flagFPulse = 1'b0;
  logic [7:0] boardIn = '0;
  logic [7:0] expIn = '0;
  logic [3:0] opcode;
  logic       readBit;
  logic [7:0] boardOut;
  logic [7:0] expOut;
  logic       flagZeroLed;
  logic       flagFLed;

  int total = 0;
  int bad = 0;
  logic [15:0] model = '0;

  always #4 clk = ~clk;  // 125 MHz

  wq_io_decoder u0 (
    .clk(clk), .rst(rst), .progWord(progWord), .writeStb(writeStb),
    .dataOut(dataOut), .flagZeroPulse(flagZeroPulse), .flagFPulse(flagFPulse),
    .boardIn(boardIn), .expIn(expIn), .opcode(opcode), .readBit(readBit),
    .boardOut(boardOut), .expOut(expOut), .flagZeroLed(flagZeroLed),
    .flagFLed(flagFLed)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // Advance to a point just after the next rising edge.
  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic writeBit(input logic [3:0] a, input logic v);
    progWord = {4'hC, a};
    dataOut  = v;
    writeStb = 1'b1;
    #1;
    check("R4 readBit during write", readBit, 0);
    tick();
    writeStb = 1'b0;
    model[a] = v;
  endtask

  task automatic testReset();
    rst = 1'b1;
    repeat (3) tick();
    check("R8 outputs after reset", {expOut, boardOut}, 0);
    check("R8 flags after reset", {flagZeroLed, flagFLed}, 0);
    rst = 1'b0;
    tick();
  endtask

  task automatic testOpcode();
    for (int w = 0; w < 256; w += 37) begin
      progWord = 8'(w);
      #1;
      check("R1 opcode nibble", opcode, w >> 4);
    end
  endtask

  task automatic testReads();
    logic [7:0] pats [3] = '{8'hA5, 8'h3C, 8'hFF};
    for (int p = 0; p < 3; p++) begin
      boardIn = pats[p];
      expIn   = ~pats[p] ^ 8'h0F;
      for (int a = 0; a < 16; a++) begin
        progWord = {4'h1, 4'(a)};
        #1;
        check("R2 input select", readBit,
              a[3] ? expIn[a[2:0]] : boardIn[a[2:0]]);
      end
    end
  endtask

  task automatic testEnableBit();
    boardIn = 8'h01;
    expIn   = 8'hFE;
    progWord = 8'h10;
    #1;
    check("R3 enable bit high", readBit, 1);
    boardIn = 8'hFE;
    expIn   = 8'h01;
    #1;
    check("R3 enable bit low", readBit, 0);
    writeStb = 1'b1;
    boardIn  = 8'hFF;
    expIn    = 8'hFF;
    #1;
    check("R4 read silent with WRITE", readBit, 0);
    writeStb = 1'b0;
    tick();
  endtask

  task automatic testWrites();
    for (int a = 0; a < 16; a++) begin
      writeBit(4'(a), a[0] ^ a[3]);
      check("R5 write capture", {expOut, boardOut}, model);
    end
    writeBit(4'h9, 1'b0);
    check("R6 single latch changes", {expOut, boardOut}, model);
    writeBit(4'h2, 1'b1);
    check("R5 onboard bank bit2", boardOut[2], 1);
    check("R6 expansion untouched", expOut, model[15:8]);
  endtask

  task automatic testHold();
    for (int k = 0; k < 20; k++) begin
      progWord = {4'h3, 4'(k)};
      dataOut  = ~dataOut;
      tick();
    end
    check("R6 hold while WRITE low", {expOut, boardOut}, model);
  endtask

  task automatic testFlags();
    flagZeroPulse = 1'b1;
    tick();
    flagZeroPulse = 1'b0;
    check("R7 first flag set", flagZeroLed, 1);
    check("R9 second flag untouched", flagFLed, 0);
    repeat (4) tick();
    writeBit(4'h5, 1'b1);
    check("R7 first flag sticky", flagZeroLed, 1);
    flagFPulse = 1'b1;
    tick();
    flagFPulse = 1'b0;
    repeat (3) tick();
    check("R7 both flags held", {flagZeroLed, flagFLed}, 2'b11);
  endtask

  task automatic testResetPriority();
    writeBit(4'hB, 1'b1);
    rst = 1'b1;
    writeStb = 1'b1;
    dataOut = 1'b1;
    progWord = 8'h0B;
    flagZeroPulse = 1'b1;
    flagFPulse = 1'b1;
    tick();
    writeStb = 1'b0;
    flagZeroPulse = 1'b0;
    flagFPulse = 1'b0;
    model = '0;
    check("R8 reset beats write", {expOut, boardOut}, 0);
    check("R8 reset beats flags", {flagZeroLed, flagFLed}, 0);
    rst = 1'b0;
    tick();
    flagFPulse = 1'b1;
    tick();
    flagFPulse = 1'b0;
    check("R9 F pulse alone", {flagZeroLed, flagFLed}, 2'b01);
  endtask

  initial begin
    fork
      begin
        #2;
        testReset();
        testOpcode();
        testReads();
        testEnableBit();
        testWrites();
        testHold();
        testFlags();
        testResetPriority();
      end
      begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    disable fork;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule